// File: doc/BRIEF.md
# Streaming mode control register

This block keeps the two-bit architectural state that steers a vector unit between its normal and streaming operating modes. It also says whether the matrix accumulator storage may be used. One bit selects streaming mode. The other marks the matrix storage as live. The block watches the system-register access bus, which carries the five encoding fields, a read/write flag and a 64-bit source operand. It responds only to encodings it recognises. Every other access leaves its state untouched.

Software can change the state in two ways. A full register write loads both bits from the operand. A short immediate form updates the mode bit, the enable bit, or both, using a single value carried in the encoding itself. A read returns the two bits zero-extended to 64 bits. The read path is combinational, so a read in the cycle after a write already sees the new value.

When the enable bit goes from 0 to 1, the block raises a one-cycle request to clear the whole matrix storage. It also drives a vector-length value chosen by the current mode. The storage array and the permission checks sit outside this block.

Top module: `smc_ctrl`

## Requirements
- R1: Under a synchronous active-high reset, both bits go to 0. The clear request is 0 and a read returns 0.
- R2: A read with acc_write=0 and encoding op0=11, op1=011, CRn=0100, CRm=0010, op2=010 sets rd_hit=1. It returns rd_data with bit 0 = mode, bit 1 = enable and bits 63:2 = 0.
- R3: A write with acc_write=1 and the same encoding as R2 loads the mode bit from wr_data[0] and the enable bit from wr_data[1]. All other operand bits are ignored.
- R4: An immediate write has acc_write=1, op0=00, op1=011, CRn=0100 and op2=011. CRm[3:1]=001 updates only the mode bit, 010 only the enable bit, and 011 both. The value written is CRm[0], and any bit not selected keeps its value.
- R5: When a write takes the enable bit from 0 to 1, clear_req is 1 for exactly one cycle. That cycle is the one right after the write's clock edge.
- R6: No clear request is raised when the enable bit stays at 1, when it is cleared, or when only the mode bit is written.
- R7: A read in the cycle right after a write returns the value that write produced.
- R8: Any access whose encoding matches neither form changes nothing and gives rd_hit=0 and rd_data=0. This includes CRm[3:1] of 000 or 1xx in immediate space, any mismatching field, and a read of the immediate encoding.
- R9: vec_len equals STREAM_VL while the mode bit is 1 and NORMAL_VL while it is 0. streaming and matrix_en show the two held bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| wr_data | input | 64 | Source operand for a full write |
| rd_hit | output | 1 | The current access is a recognised read |
| rd_data | output | 64 | Read result, zero when rd_hit is 0 |
| streaming | output | 1 | Current mode bit |
| matrix_en | output | 1 | Current storage-enable bit |
| clear_req | output | 1 | One-cycle request to zero the matrix storage |
| vec_len | output | VLW | Active vector length for the current mode |

## Verification
Some behaviours hold in every cycle and are checked there:
- the clear request appears only together with a rise of the enable bit, and every such rise produces it;
- a bit that no decoded write selects keeps its value;
- the decoder never flags more than one access kind at once.

Other behaviours depend on specific encodings and operand values, so only the bench's scenarios can show them. These are:
- which CRm patterns reach which bit;
- that upper operand bits are ignored;
- that a read right after a write sees the new value;
- that near-miss encodings are rejected;
- how the vector length follows the mode.

// File: rtl/smc_pkg.sv
package smc_pkg;

  // Full-register access encoding
  localparam logic [1:0] FULL_OP0 = 2'b11;
  localparam logic [2:0] FULL_OP1 = 3'b011;
  localparam logic [3:0] FULL_CRN = 4'b0100;
  localparam logic [3:0] FULL_CRM = 4'b0010;
  localparam logic [2:0] FULL_OP2 = 3'b010;

  // Immediate-form encoding (CRm carries selector and value)
  localparam logic [1:0] IMM_OP0 = 2'b00;
  localparam logic [2:0] IMM_OP1 = 3'b011;
  localparam logic [3:0] IMM_CRN = 4'b0100;
  localparam logic [2:0] IMM_OP2 = 3'b011;

  // CRm[3:1] selectors for the immediate form
  localparam logic [2:0] SEL_MODE = 3'b001;
  localparam logic [2:0] SEL_EN   = 3'b010;
  localparam logic [2:0] SEL_BOTH = 3'b011;

  typedef struct packed {
    logic rd_hit;   // recognised read of the full register
    logic wr_full;  // recognised full write
    logic wr_imm;   // recognised immediate write
    logic upd_mode; // mode bit is written
    logic upd_en;   // enable bit is written
    logic val_mode; // value for mode bit
    logic val_en;   // value for enable bit
  } smc_dec_t;

  function automatic logic is_full_enc(input logic [1:0] op0, input logic [2:0] op1,
                                       input logic [3:0] crn, input logic [3:0] crm,
                                       input logic [2:0] op2);
    return (op0 == FULL_OP0) && (op1 == FULL_OP1) && (crn == FULL_CRN) &&
           (crm == FULL_CRM) && (op2 == FULL_OP2);
  endfunction

  function automatic logic is_imm_space(input logic [1:0] op0, input logic [2:0] op1,
                                        input logic [3:0] crn, input logic [2:0] op2);
    return (op0 == IMM_OP0) && (op1 == IMM_OP1) && (crn == IMM_CRN) && (op2 == IMM_OP2);
  endfunction

  function automatic logic sel_hits_mode(input logic [2:0] sel);
    return (sel == SEL_MODE) || (sel == SEL_BOTH);
  endfunction

  function automatic logic sel_hits_en(input logic [2:0] sel);
    return (sel == SEL_EN) || (sel == SEL_BOTH);
  endfunction

  // Read image: zero-extend {enable, mode}
  function automatic logic [63:0] read_image(input logic mode, input logic en);
    return {62'd0, en, mode};
  endfunction

endpackage

// File: rtl/smc_decode.sv
module smc_decode
  import smc_pkg::*;
(
  input  logic        valid,
  input  logic        write,
  input  logic [1:0]  op0,
  input  logic [2:0]  op1,
  input  logic [3:0]  crn,
  input  logic [3:0]  crm,
  input  logic [2:0]  op2,
  input  logic [1:0]  src_bits,
  output smc_dec_t    dec
);

  logic full_enc;
  logic imm_space;
  logic imm_sel_mode;
  logic imm_sel_en;

  always_comb begin
    full_enc     = is_full_enc(op0, op1, crn, crm, op2);
    imm_space    = is_imm_space(op0, op1, crn, op2);
    imm_sel_mode = sel_hits_mode(crm[3:1]);
    imm_sel_en   = sel_hits_en(crm[3:1]);

    dec          = '0;
    dec.rd_hit   = valid && !write && full_enc;
    dec.wr_full  = valid && write && full_enc;
    dec.wr_imm   = valid && write && imm_space && (imm_sel_mode || imm_sel_en);

    if (dec.wr_full) begin
      dec.upd_mode = 1'b1;
      dec.upd_en   = 1'b1;
      dec.val_mode = src_bits[0];
      dec.val_en   = src_bits[1];
    end else if (dec.wr_imm) begin
      dec.upd_mode = imm_sel_mode;
      dec.upd_en   = imm_sel_en;
      dec.val_mode = crm[0];
      dec.val_en   = crm[0];
    end
  end

endmodule

// File: rtl/smc_state.sv
module smc_state
  import smc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  smc_dec_t dec,
  output logic     mode_q,
  output logic     en_q,
  output logic     clear_q
);

  logic mode_d;
  logic en_d;
  logic en_rise;

  always_comb begin
    mode_d  = dec.upd_mode ? dec.val_mode : mode_q;
    en_d    = dec.upd_en   ? dec.val_en   : en_q;
    en_rise = dec.upd_en && dec.val_en && !en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      en_q    <= en_d;
      clear_q <= en_rise;
    end
  end

  // R5
  clear_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    clear_q |-> (en_q && !$past(en_q)));

  // R6
  no_missed_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && !$past(en_q)) |-> clear_q);

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dec.upd_mode |=> $stable(mode_q));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dec.upd_en |=> $stable(en_q));

endmodule

// File: rtl/smc_vlsel.sv
module smc_vlsel #(
  parameter int NORMAL_VL = 256,
  parameter int STREAM_VL = 512,
  parameter int VLW       = 10
) (
  input  logic           mode,
  output logic [VLW-1:0] vec_len
);

  localparam logic [VLW-1:0] NORM_V = VLW'(NORMAL_VL);
  localparam logic [VLW-1:0] STRM_V = VLW'(STREAM_VL);

  generate
    if (NORMAL_VL == STREAM_VL) begin : g_same
      logic unused_mode;
      assign unused_mode = mode;
      assign vec_len = NORM_V;
    end else begin : g_mux
      assign vec_len = mode ? STRM_V : NORM_V;
    end
  endgenerate

endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
#(
  parameter int NORMAL_VL = 256,
  parameter int STREAM_VL = 512,
  localparam int VLMAX    = (NORMAL_VL > STREAM_VL) ? NORMAL_VL : STREAM_VL,
  localparam int VLW      = $clog2(VLMAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           acc_valid,
  input  logic           acc_write,
  input  logic [1:0]     acc_op0,
  input  logic [2:0]     acc_op1,
  input  logic [3:0]     acc_crn,
  input  logic [3:0]     acc_crm,
  input  logic [2:0]     acc_op2,
  input  logic [63:0]    wr_data,
  output logic           rd_hit,
  output logic [63:0]    rd_data,
  output logic           streaming,
  output logic           matrix_en,
  output logic           clear_req,
  output logic [VLW-1:0] vec_len
);

  smc_dec_t dec;
  logic     mode_q;
  logic     en_q;
  logic     clear_q;
  logic     unused_wr_hi;

  // Only operand bits [1:0] carry state; the rest are discarded.
  assign unused_wr_hi = ^wr_data[63:2];

  smc_decode u_dec (
    .valid    (acc_valid),
    .write    (acc_write),
    .op0      (acc_op0),
    .op1      (acc_op1),
    .crn      (acc_crn),
    .crm      (acc_crm),
    .op2      (acc_op2),
    .src_bits (wr_data[1:0]),
    .dec      (dec)
  );

  smc_state u_state (
    .clk     (clk),
    .rst     (rst),
    .dec     (dec),
    .mode_q  (mode_q),
    .en_q    (en_q),
    .clear_q (clear_q)
  );

  smc_vlsel #(
    .NORMAL_VL (NORMAL_VL),
    .STREAM_VL (STREAM_VL),
    .VLW       (VLW)
  ) u_vl (
    .mode    (mode_q),
    .vec_len (vec_len)
  );

  assign rd_hit    = dec.rd_hit;
  assign rd_data   = dec.rd_hit ? read_image(mode_q, en_q) : 64'd0;
  assign streaming = mode_q;
  assign matrix_en = en_q;
  assign clear_req = clear_q;

  // R8
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec.rd_hit, dec.wr_full, dec.wr_imm}));

  // R2
  read_image_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> (rd_data[63:2] == 62'd0 && rd_data[0] == streaming && rd_data[1] == matrix_en));

endmodule

// File: tb/test_smc_ctrl.sv
`timescale 1ns/1ps
module test_smc_ctrl;

  localparam int NVL = 256;
  localparam int SVL = 512;
  localparam int VW  = $clog2(SVL + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_valid, acc_write;
  logic [1:0]    acc_op0;
  logic [2:0]    acc_op1;
  logic [3:0]    acc_crn, acc_crm;
  logic [2:0]    acc_op2;
  logic [63:0]   wr_data;
  logic          rd_hit;
  logic [63:0]   rd_data;
  logic          streaming, matrix_en, clear_req;
  logic [VW-1:0] vec_len;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  smc_ctrl #(.NORMAL_VL(NVL), .STREAM_VL(SVL)) i_smc_ctrl (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
    .acc_op2(acc_op2), .wr_data(wr_data), .rd_hit(rd_hit), .rd_data(rd_data),
    .streaming(streaming), .matrix_en(matrix_en), .clear_req(clear_req), .vec_len(vec_len)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  op0;
    logic [2:0]  op1;
    logic [3:0]  crn;
    logic [3:0]  crm;
    logic [2:0]  op2;
    logic [63:0] data;
    logic        exp_mode;
    logic        exp_en;
    logic        exp_clr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b11, 3'b011, 4'b0100, 4'b0010, 3'b010, 64'hA5A5_0000_FFFF_FFF3, 1'b1, 1'b1, 1'b1}, // R3 R5 full both
    '{1'b1, 2'b11, 3'b011, 4'b0100, 4'b0010, 3'b010, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1, 1'b0}, // R6 en stays 1
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b0011, 3'b011, 64'h0, 1'b1, 1'b1, 1'b0},                    // R4 mode only
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b0100, 3'b011, 64'h0, 1'b1, 1'b0, 1'b0},                    // R4 R6 en cleared
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b0101, 3'b011, 64'h0, 1'b1, 1'b1, 1'b1},                    // R4 R5 en set
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b0110, 3'b011, 64'h0, 1'b0, 1'b0, 1'b0},                    // R4 both 0
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b0111, 3'b011, 64'h0, 1'b1, 1'b1, 1'b1},                    // R4 R5 both 1
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b0000, 3'b011, 64'h0, 1'b1, 1'b1, 1'b0},                    // R8 sel 000
    '{1'b1, 2'b11, 3'b011, 4'b0100, 4'b0010, 3'b011, 64'h0, 1'b1, 1'b1, 1'b0},                    // R8 op2 off
    '{1'b0, 2'b11, 3'b011, 4'b0100, 4'b0010, 3'b010, 64'h0, 1'b1, 1'b1, 1'b0},                    // R2 plain read
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b0100, 3'b011, 64'h0, 1'b1, 1'b0, 1'b0},                    // R4 en off
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b1101, 3'b011, 64'h0, 1'b1, 1'b0, 1'b0},                    // R8 sel 110
    '{1'b1, 2'b11, 3'b011, 4'b0100, 4'b0010, 3'b010, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b0, 1'b0}, // R3 upper ignored
    '{1'b1, 2'b00, 3'b010, 4'b0100, 4'b0111, 3'b011, 64'h0, 1'b0, 1'b0, 1'b0},                    // R8 op1 off
    '{1'b1, 2'b00, 3'b011, 4'b0100, 4'b0011, 3'b011, 64'h0, 1'b1, 1'b0, 1'b0}                     // R6 mode only, en 0
  };

  function automatic logic [VW-1:0] exp_vl(input logic m);
    if (m) return VW'(SVL);
    return VW'(NVL);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 1'b0; acc_write = 1'b0;
    acc_op0 = '0; acc_op1 = '0; acc_crn = '0; acc_crm = '0; acc_op2 = '0;
    wr_data = '0;
  endtask

  task automatic drive_full_read();
    acc_valid = 1'b1; acc_write = 1'b0;
    acc_op0 = 2'b11; acc_op1 = 3'b011; acc_crn = 4'b0100; acc_crm = 4'b0010; acc_op2 = 3'b010;
    wr_data = '0;
  endtask

  task automatic drive_vec(input vec_t v);
    acc_valid = 1'b1; acc_write = v.wr;
    acc_op0 = v.op0; acc_op1 = v.op1; acc_crn = v.crn; acc_crm = v.crm; acc_op2 = v.op2;
    wr_data = v.data;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    drive_full_read();
    #0.5;
    check("R1 mode", 64'(streaming), 64'd0);
    check("R1 enable", 64'(matrix_en), 64'd0);
    check("R1 clear", 64'(clear_req), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    check("R1 read", rd_data, 64'd0);
    check("R9 normal vl", 64'(vec_len), 64'(exp_vl(1'b0)));

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check("R5 clear idle", 64'(clear_req), 64'd0);
      drive_vec(VECS[i]);
      #0.5;
      if (!(VECS[i].wr == 1'b0 && VECS[i].op0 == 2'b11))
        check("R8 rd_hit on write", 64'(rd_hit), 64'd0);
      @(negedge clk);
      drive_full_read();
      #0.5;
      check("R3/R4 mode", 64'(streaming), 64'(VECS[i].exp_mode));
      check("R3/R4 enable", 64'(matrix_en), 64'(VECS[i].exp_en));
      check("R5/R6 clear", 64'(clear_req), 64'(VECS[i].exp_clr));
      check("R7 readback", rd_data, {62'd0, VECS[i].exp_en, VECS[i].exp_mode});
      check("R2 rd_hit", 64'(rd_hit), 64'd1);
      check("R9 vl", 64'(vec_len), 64'(exp_vl(VECS[i].exp_mode)));
    end

    // R5: pulse lasts one cycle even with a following idle
    @(negedge clk);
    idle();
    acc_valid = 1'b1; acc_write = 1'b1;
    acc_op0 = 2'b00; acc_op1 = 3'b011; acc_crn = 4'b0100; acc_crm = 4'b0101; acc_op2 = 3'b011;
    @(negedge clk);
    idle();
    #0.5;
    check("R5 pulse high", 64'(clear_req), 64'd1);
    @(negedge clk);
    #0.5;
    check("R5 pulse width", 64'(clear_req), 64'd0);

    // R8: read of the immediate encoding is not a hit
    acc_valid = 1'b1; acc_write = 1'b0;
    acc_op0 = 2'b00; acc_op1 = 3'b011; acc_crn = 4'b0100; acc_crm = 4'b0111; acc_op2 = 3'b011;
    #0.5;
    check("R8 imm read hit", 64'(rd_hit), 64'd0);
    check("R8 imm read data", rd_data, 64'd0);
    @(negedge clk);
    idle();
    #0.5;
    check("R8 imm read no change", 64'(matrix_en), 64'd1);

    // R1: reset in mid-operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    check("R1 mid reset mode", 64'(streaming), 64'd0);
    check("R1 mid reset en", 64'(matrix_en), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule